// File: doc/BRIEF.md
# Endpoint FIFO Segment Allocator

This block hands out space in a shared endpoint FIFO memory. The memory is treated as a row of fixed 512-byte units, and an occupancy bitmap with one bit per unit records which units are taken. A transmit FIFO and a receive FIFO each get their own instance.

An allocate request carries an endpoint's maximum packet size and a slot count. The block rounds the packet size up to a power of two and multiplies it by the slot count plus one. It converts that size to whole units and then scans the bitmap from unit 0 upward, one candidate start per cycle, for the first run of free units that is long enough. On a hit it marks the run as occupied and returns the base address of the FIFO plus the start unit times 512. On a miss it raises a fail flag and the bitmap is left as it was.

A free request carries a byte address and a byte size and clears the units they cover. A free is applied in the cycle it arrives, including while a search is running.

Top module: `epfifo_seg_alloc`

## Requirements
- R1: After reset every unit is free, and `busy`, `done` and `fail` are low.
- R2: An allocation needs ceil(P*(slot+1)/512) units. P is `allocMaxp` rounded up to the next power of two, and a packet size of 0 counts as 1.
- R3: A search picks the lowest start unit s at which the needed units are all free and fit below the limit. It returns `allocAddr` = `baseAddr` + s*512, with `fail` low.
- R4: A successful allocation marks its units as occupied, so later searches skip them.
- R5: When no fitting run exists, `fail` is raised together with `done`, and no unit changes state.
- R6: Only units below `limitIn` take part in a search. A value of `limitIn` above 128 counts as 128. The limit is captured when the request is accepted.
- R7: A free clears the units from (`freeAddr`-`baseAddr`)/512 onward, ceil(`freeBytes`/512) of them (at least 1). Units past the end of the map are dropped. Freeing a unit that is already free changes nothing.
- R8: `done` is a one-cycle pulse. Count clock edges from the edge that samples the request. The pulse appears s+1 edges later for a hit at start s. For a miss it appears limit-n+2 edges later, or 1 edge later when the request needs more units than the limit.
- R9: An allocate request that arrives while `busy` is high is dropped. It produces no second `done`.
- R10: When a free and an allocate request arrive in the same cycle, the free is applied first and the search sees the released units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | 32 | Byte address of FIFO unit 0 |
| limitIn | input | 8 | Number of usable units, capped at 128 |
| allocReq | input | 1 | Allocate request pulse |
| allocMaxp | input | 16 | Maximum packet size in bytes |
| allocSlot | input | 2 | Slot count; the size is multiplied by this plus one |
| freeReq | input | 1 | Free request pulse |
| freeAddr | input | 32 | Byte address of the region to release |
| freeBytes | input | 32 | Byte size of the region to release |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse that ends a search |
| fail | output | 1 | Pulses with `done` when the search found no space |
| allocAddr | output | 32 | Granted base address, valid with `done` when `fail` is low |

## Verification
A free and an allocate request can meet in one cycle. A free can also land on the same edge as the search's commit. The bench fills the whole map and then drives a free of the first eight units in the same cycle as an eight-unit allocation. It expects a hit at unit 0 one edge after the request. If the free were applied late, the search would run into a miss after 122 edges. In the random phase, frees and allocations are interleaved, and every grant address and latency is compared against the bench's own bitmap model.

// File: rtl/fifoalloc_pkg.sv
package fifoalloc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new request, restart at unit 0
    logic step;    // move to the next candidate start
    logic commit;  // mark the window occupied and report a hit
    logic miss;    // report a failed search
  } ctrl_strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic fits;       // current window is free and inside the limit
    logic exhausted;  // window runs past the limit
  } dp_status_t;
endpackage

// File: rtl/fifoalloc_range_mask.sv
module fifoalloc_range_mask #(
  parameter int MAP_BITS = 128,
  parameter int IDX_W    = 23,
  parameter int LEN_W    = 24
) (
  input  logic [IDX_W-1:0]    startIdx,
  input  logic [LEN_W-1:0]    runLen,
  output logic [MAP_BITS-1:0] mask
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] endIdx;
  assign endIdx = SUM_W'(startIdx) + SUM_W'(runLen);

  for (genvar i = 0; i < MAP_BITS; i++) begin : g_bit
    assign mask[i] = (SUM_W'(i) >= SUM_W'(startIdx)) && (SUM_W'(i) < endIdx);
  end
endmodule

// File: rtl/fifoalloc_ctrl.sv
module fifoalloc_ctrl
  import fifoalloc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         allocReq,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         busy
);
  logic busyQ;

  always_comb begin
    strobe = '0;
    if (!busyQ) begin
      strobe.load = allocReq;
    end else if (status.exhausted) begin
      strobe.miss = 1'b1;
    end else if (status.fits) begin
      strobe.commit = 1'b1;
    end else begin
      strobe.step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (strobe.load) begin
      busyQ <= 1'b1;
    end else if (strobe.commit || strobe.miss) begin
      busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/fifoalloc_datapath.sv
module fifoalloc_datapath
  import fifoalloc_pkg::*;
#(
  parameter int MAP_BITS   = 128,
  parameter int UNIT_BYTES = 512,
  parameter int ADDR_W     = 32,
  parameter int MAXP_W     = 16,
  parameter int SLOT_W     = 2,
  parameter int LIM_W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [LIM_W-1:0]    limitIn,
  input  logic [MAXP_W-1:0]   allocMaxp,
  input  logic [SLOT_W-1:0]   allocSlot,
  input  logic                freeReq,
  input  logic [ADDR_W-1:0]   freeAddr,
  input  logic [ADDR_W-1:0]   freeBytes,
  input  ctrl_strobe_t        strobe,
  output dp_status_t          status,
  output logic [MAP_BITS-1:0] occMap,
  output logic                done,
  output logic                fail,
  output logic [ADDR_W-1:0]   allocAddr
);
  localparam int UNIT_SHIFT = $clog2(UNIT_BYTES);
  localparam int CAND_W     = $clog2(MAP_BITS + 1);
  localparam int TOT_W      = MAXP_W + 1 + SLOT_W;
  localparam int NEED_W     = TOT_W - UNIT_SHIFT + 1;
  localparam int IDX_W      = ADDR_W - UNIT_SHIFT;
  localparam int LEN_W      = IDX_W + 1;
  localparam int CMP_W      = NEED_W + 1;

  // Units for one endpoint: pow2(maxp) * (slot+1), rounded up to units
  function automatic logic [NEED_W-1:0] unitsFor(input logic [MAXP_W-1:0] maxp,
                                                 input logic [SLOT_W-1:0] slot);
    logic [TOT_W:0] seg;
    logic [TOT_W:0] total;
    seg = (TOT_W+1)'(1);
    for (int i = 0; i < MAXP_W; i++) begin
      if (seg < (TOT_W+1)'(maxp)) seg = seg << 1;
    end
    total = seg * ((TOT_W+1)'(slot) + (TOT_W+1)'(1));
    total = total + (TOT_W+1)'(UNIT_BYTES - 1);
    return NEED_W'(total >> UNIT_SHIFT);
  endfunction

  logic [MAP_BITS-1:0] mapQ;
  logic [CAND_W-1:0]   candQ;
  logic [NEED_W-1:0]   needQ;
  logic [CAND_W-1:0]   limitQ;
  logic                doneQ, failQ;
  logic [ADDR_W-1:0]   addrQ;

  // Window under test
  logic [MAP_BITS-1:0] winMask;
  fifoalloc_range_mask #(.MAP_BITS(MAP_BITS), .IDX_W(IDX_W), .LEN_W(LEN_W)) win_mask_i (
    .startIdx(IDX_W'(candQ)),
    .runLen  (LEN_W'(needQ)),
    .mask    (winMask)
  );

  // Region being released
  logic [ADDR_W-1:0] freeOffset;
  logic [ADDR_W:0]   freeRound;
  logic [LEN_W-1:0]  freeLen;
  logic [MAP_BITS-1:0] freeRange, freeMask;
  assign freeOffset = freeAddr - baseAddr;
  assign freeRound  = {1'b0, freeBytes} + (ADDR_W+1)'(UNIT_BYTES - 1);
  assign freeLen    = (freeRound[ADDR_W:UNIT_SHIFT] == '0) ? LEN_W'(1)
                                                           : freeRound[ADDR_W:UNIT_SHIFT];

  fifoalloc_range_mask #(.MAP_BITS(MAP_BITS), .IDX_W(IDX_W), .LEN_W(LEN_W)) free_mask_i (
    .startIdx(freeOffset[ADDR_W-1:UNIT_SHIFT]),
    .runLen  (freeLen),
    .mask    (freeRange)
  );
  assign freeMask = freeReq ? freeRange : '0;

  // Search status
  logic [CMP_W-1:0] windowEnd;
  assign windowEnd        = CMP_W'(candQ) + CMP_W'(needQ);
  assign status.exhausted = windowEnd > CMP_W'(limitQ);
  assign status.fits      = !status.exhausted && ((mapQ & winMask) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapQ   <= '0;
      candQ  <= '0;
      needQ  <= '0;
      limitQ <= '0;
      doneQ  <= 1'b0;
      failQ  <= 1'b0;
      addrQ  <= '0;
    end else begin
      mapQ  <= (mapQ & ~freeMask) | (strobe.commit ? winMask : '0);
      doneQ <= strobe.commit || strobe.miss;
      failQ <= strobe.miss;
      if (strobe.load) begin
        candQ  <= '0;
        needQ  <= unitsFor(allocMaxp, allocSlot);
        limitQ <= (limitIn > LIM_W'(MAP_BITS)) ? CAND_W'(MAP_BITS) : CAND_W'(limitIn);
      end else if (strobe.step) begin
        candQ <= candQ + CAND_W'(1);
      end
      if (strobe.commit) addrQ <= baseAddr + (ADDR_W'(candQ) << UNIT_SHIFT);
      else if (strobe.miss) addrQ <= '0;
    end
  end

  assign occMap    = mapQ;
  assign done      = doneQ;
  assign fail      = failQ;
  assign allocAddr = addrQ;
endmodule

// File: rtl/epfifo_seg_alloc.sv
module epfifo_seg_alloc
  import fifoalloc_pkg::*;
#(
  parameter int MAP_BITS   = 128,
  parameter int UNIT_BYTES = 512,
  parameter int ADDR_W     = 32,
  parameter int MAXP_W     = 16,
  parameter int SLOT_W     = 2,
  parameter int LIM_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [LIM_W-1:0]  limitIn,
  input  logic              allocReq,
  input  logic [MAXP_W-1:0] allocMaxp,
  input  logic [SLOT_W-1:0] allocSlot,
  input  logic              freeReq,
  input  logic [ADDR_W-1:0] freeAddr,
  input  logic [ADDR_W-1:0] freeBytes,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] allocAddr
);
  ctrl_strobe_t        strobe;
  dp_status_t          status;
  logic [MAP_BITS-1:0] occMap;

  fifoalloc_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .allocReq(allocReq),
    .status  (status),
    .strobe  (strobe),
    .busy    (busy)
  );

  fifoalloc_datapath #(
    .MAP_BITS(MAP_BITS), .UNIT_BYTES(UNIT_BYTES), .ADDR_W(ADDR_W),
    .MAXP_W(MAXP_W), .SLOT_W(SLOT_W), .LIM_W(LIM_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .baseAddr (baseAddr),
    .limitIn  (limitIn),
    .allocMaxp(allocMaxp),
    .allocSlot(allocSlot),
    .freeReq  (freeReq),
    .freeAddr (freeAddr),
    .freeBytes(freeBytes),
    .strobe   (strobe),
    .status   (status),
    .occMap   (occMap),
    .done     (done),
    .fail     (fail),
    .allocAddr(allocAddr)
  );
endmodule

// File: rtl/epfifo_seg_alloc_chk.sv
module epfifo_seg_alloc_chk #(
  parameter int MAP_BITS = 128
) (
  input logic                clk,
  input logic                rstN,
  input logic                freeReq,
  input logic                busy,
  input logic                done,
  input logic                fail,
  input logic [MAP_BITS-1:0] occMap
);
  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: fail only comes with done
  a_r5_fail_with_done: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done);

  // R9: a done always closes a search that was running
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R4: occupancy moves only on a free or at the end of a search
  a_r4_map_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(freeReq) && !done) |-> $stable(occMap));

  // R5: a miss leaves the map alone
  a_r5_miss_keeps_map: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail && !$past(freeReq)) |-> $stable(occMap));

  // R4: a hit only adds occupied units, and adds at least one
  a_r4_hit_sets_bits: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fail && !$past(freeReq)) |->
      (((occMap & $past(occMap)) == $past(occMap)) && (occMap != $past(occMap))));
endmodule

bind epfifo_seg_alloc epfifo_seg_alloc_chk #(.MAP_BITS(MAP_BITS)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .freeReq(freeReq),
  .busy   (busy),
  .done   (done),
  .fail   (fail),
  .occMap (occMap)
);

// File: tb/epfifo_seg_alloc_tb_top.sv
`timescale 1ns/1ps
module epfifo_seg_alloc_tb_top;
  localparam int BASE = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] baseAddr = BASE;
  logic [7:0]  limitIn = 8'd128;
  logic        allocReq = 1'b0;
  logic [15:0] allocMaxp = '0;
  logic [1:0]  allocSlot = '0;
  logic        freeReq = 1'b0;
  logic [31:0] freeAddr = '0;
  logic [31:0] freeBytes = '0;
  logic        busy, done, fail;
  logic [31:0] allocAddr;

  always #2 clk = ~clk;

  epfifo_seg_alloc dut_i (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .limitIn(limitIn),
    .allocReq(allocReq), .allocMaxp(allocMaxp), .allocSlot(allocSlot),
    .freeReq(freeReq), .freeAddr(freeAddr), .freeBytes(freeBytes),
    .busy(busy), .done(done), .fail(fail), .allocAddr(allocAddr)
  );

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  bit model [128];
  int recAddr [64];
  int recBytes [64];
  int recCnt = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int segOf(int maxp);
    int seg = 1;
    while (seg < maxp) seg = seg * 2;
    return seg;
  endfunction

  function automatic int unitsFor(int maxp, int slot);
    return (segOf(maxp) * (slot + 1) + 511) / 512;
  endfunction

  function automatic int effLimit();
    return (limitIn > 128) ? 128 : int'(limitIn);
  endfunction

  function automatic int findFit(int n, int lim);
    for (int s = 0; s + n <= lim; s++) begin
      bit ok = 1;
      for (int j = 0; j < n; j++) if (model[s + j]) ok = 0;
      if (ok) return s;
    end
    return -1;
  endfunction

  function automatic void modelFree(int addr, int bytes);
    int start = (addr - BASE) / 512;
    int n = (bytes + 511) / 512;
    if (n == 0) n = 1;
    for (int i = start; i < start + n; i++) if (i >= 0 && i < 128) model[i] = 0;
  endfunction

  // Allocate; injectAt > 0 pulses a second request during the search (R9)
  task automatic doAlloc(int maxp, int slot, string tag, int injectAt = 0);
    int n = unitsFor(maxp, slot);
    int lim = effLimit();
    int s = findFit(n, lim);
    int expLat = (s >= 0) ? s + 1 : ((n > lim) ? 1 : lim - n + 2);
    int cnt;
    @(negedge clk);
    allocMaxp = 16'(maxp); allocSlot = 2'(slot); allocReq = 1'b1;
    @(negedge clk);
    allocReq = 1'b0;
    cnt = 1;
    while (!done && cnt < 400) begin
      @(negedge clk);
      cnt++;
      allocReq = (injectAt > 0 && cnt == injectAt);
      if (allocReq) allocMaxp = 16'd1;
    end
    allocReq = 1'b0;
    check(cnt - 1 == expLat, "R8", {tag, " latency"}, cnt - 1, expLat);
    check(fail == (s < 0), (s < 0) ? "R5" : "R3", {tag, " fail flag"}, fail, s < 0);
    if (s >= 0) begin
      check(allocAddr == BASE + s * 512, "R3", {tag, " address"}, allocAddr, BASE + s * 512);
      for (int j = 0; j < n; j++) model[s + j] = 1;
      if (recCnt < 64) begin
        recAddr[recCnt] = BASE + s * 512;
        recBytes[recCnt] = segOf(maxp) * (slot + 1);
        recCnt++;
      end
    end
    @(negedge clk);
    check(!done, "R8", {tag, " done width"}, done, 0);
  endtask

  task automatic doFree(int addr, int bytes);
    @(negedge clk);
    freeAddr = addr; freeBytes = bytes; freeReq = 1'b1;
    @(negedge clk);
    freeReq = 1'b0;
    modelFree(addr, bytes);
  endtask

  task automatic freeAll();
    doFree(BASE, 65536);
    recCnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd4177));
    for (int i = 0; i < 128; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail, "R1", "idle after reset", {busy, done, fail}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fail, "R1", "idle after release", {busy, done, fail}, 0);

    // R2 sizing and R3 first-fit on an empty map
    doAlloc(512, 0, "r2_one_unit");        // 1 unit at 0
    doAlloc(513, 1, "r2_round_pow2");      // 1024*2 -> 4 units at 1
    doAlloc(0, 0, "r2_zero_maxp");         // 1 unit at 5
    doAlloc(64, 3, "r2_min_one");          // 256 bytes -> 1 unit at 6
    freeAll();
    doAlloc(16384, 3, "r7_full_after_free"); // 128 units at 0 after free
    freeAll();

    // Fill all 128 units, then a miss (R5)
    for (int k = 0; k < 16; k++) doAlloc(1024, 3, "r4_fill");
    doAlloc(1024, 3, "r5_full_miss");

    // R10: free and allocate in the same cycle
    @(negedge clk);
    freeAddr = BASE; freeBytes = 4096; freeReq = 1'b1;
    allocMaxp = 16'd1024; allocSlot = 2'd3; allocReq = 1'b1;
    @(negedge clk);
    freeReq = 1'b0; allocReq = 1'b0;
    cnt = 1;
    while (!done && cnt < 400) begin @(negedge clk); cnt++; end
    check(cnt - 1 == 1, "R10", "same-cycle latency", cnt - 1, 1);
    check(!fail && allocAddr == BASE, "R10", "same-cycle address", allocAddr, BASE);

    // R9: request during a long search is dropped
    doFree(BASE + 120 * 512, 4096);
    doAlloc(1024, 3, "r9_first", 6);
    repeat (8) begin
      @(negedge clk);
      check(!done, "R9", "no second done", done, 0);
    end

    // R6: limit
    freeAll();
    limitIn = 8'd10;
    doAlloc(1024, 3, "r6_fits_limit");
    doAlloc(1024, 3, "r6_limit_miss");
    doAlloc(16384, 3, "r6_over_limit");
    limitIn = 8'd200;
    doAlloc(1024, 3, "r6_clamped");
    limitIn = 8'd128;

    // R7: free past the end and double free
    doAlloc(8192, 3, "r7_fill_a");   // 64 units at 16
    doAlloc(4096, 3, "r7_fill_b");   // 32 units at 80
    doAlloc(4096, 1, "r7_fill_c");   // 16 units at 112
    doFree(BASE + 127 * 512, 4096);  // only unit 127 inside the map
    doAlloc(1, 0, "r7_tail_unit");   // 1 unit at 127
    doFree(BASE + 127 * 512, 512);
    doFree(BASE + 127 * 512, 512);   // already free
    doAlloc(512, 1, "r7_double_free"); // 2 units: miss
    freeAll();

    // Random mix
    for (int it = 0; it < 90; it++) begin
      if (recCnt > 0 && ($urandom_range(0, 2) == 0 || recCnt >= 60)) begin
        int k = $urandom_range(0, recCnt - 1);
        doFree(recAddr[k], recBytes[k]);
        recAddr[k] = recAddr[recCnt - 1];
        recBytes[k] = recBytes[recCnt - 1];
        recCnt--;
      end else begin
        doAlloc($urandom_range(0, 1100), $urandom_range(0, 3), "r3_random");
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule